// File: doc/BRIEF.md
# Virtual-8086 to Privileged Handler Interrupt Frame Builder

This sequencer carries out the state save and entry when an interrupt taken in virtual-8086 mode goes to a privilege-0 protected-mode handler. On a start pulse it captures the interrupted context, the gate fields and the task-state stack pair. It switches to the privilege-0 stack and writes the saved state to a stack memory port as a series of 32-bit words. When the frame is complete it presents the handler's register values together with a one-cycle done pulse.

The frame starts with the four data segment selectors, which an ordinary protected-mode frame does not hold. Those selectors are then replaced by null. The flags word goes onto the stack as it was captured. The handler copy has the trace, nested-task, resume and virtual-mode bits cleared. The interrupt-enable bit is also cleared when the gate is an interrupt gate. Descriptor fetch and privilege checks happen elsewhere.

Top module: `vm86_frame_builder`

## Requirements
- R1: After reset, wr_valid and done are 0 and every new_* output is 0.
- R2: On start the stack pointer is loaded from tss_esp0 and is decremented by 4 before each write. The first write therefore goes to tss_esp0-4, and each accepted write is followed by one 4 lower.
- R3: The first four words written are gs, fs, ds and es in that order, each zero-extended to 32 bits.
- R4: The next words are ss (zero-extended), esp, the captured flags word unmodified, cs (zero-extended) and eip, in that order.
- R5: When err_valid is 1 at start, err_code is written as the tenth and last word and the frame is 40 bytes. Otherwise nine words (36 bytes) are written. No write is issued after the frame is complete.
- R6: A write is accepted only in a cycle with wr_valid and wr_ready both 1. While wr_ready is 0, wr_addr and wr_data hold steady.
- R7: done is a one-cycle pulse in the cycle after the last write is accepted. With it come new_ss = tss_ss0 and new_esp = tss_esp0 minus the frame size.
- R8: At done, new_gs, new_fs, new_ds and new_es are 0.
- R9: new_flags is the captured flags word with bits 8, 14, 16 and 17 cleared. Bit 9 is also cleared when gate_trap is 0 (interrupt gate) and is kept when gate_trap is 1 (trap gate).
- R10: At done, new_cs equals gate_sel and new_eip equals gate_off.
- R11: A start pulse that arrives while a frame is in progress is ignored. The frame in progress and its results do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a frame (ignored while busy) |
| cur_gs | input | 16 | Interrupted GS selector |
| cur_fs | input | 16 | Interrupted FS selector |
| cur_ds | input | 16 | Interrupted DS selector |
| cur_es | input | 16 | Interrupted ES selector |
| cur_ss | input | 16 | Interrupted stack selector |
| cur_esp | input | 32 | Interrupted stack pointer |
| cur_flags | input | 32 | Interrupted flags word |
| cur_cs | input | 16 | Interrupted code selector |
| cur_eip | input | 32 | Interrupted instruction pointer |
| gate_sel | input | 16 | Handler code selector from gate |
| gate_off | input | 32 | Handler entry offset from gate |
| gate_trap | input | 1 | 1 = trap gate, 0 = interrupt gate |
| err_valid | input | 1 | Error code present |
| err_code | input | 32 | Error code value |
| tss_ss0 | input | 16 | Privilege-0 stack selector |
| tss_esp0 | input | 32 | Privilege-0 stack pointer |
| wr_ready | input | 1 | Stack memory accepts write |
| wr_valid | output | 1 | Stack write request |
| wr_addr | output | 32 | Stack write address |
| wr_data | output | 32 | Stack write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame complete pulse |
| new_ss | output | 16 | Handler stack selector |
| new_esp | output | 32 | Handler stack pointer |
| new_cs | output | 16 | Handler code selector |
| new_eip | output | 32 | Handler instruction pointer |
| new_flags | output | 32 | Handler flags |
| new_gs | output | 16 | Handler GS selector |
| new_fs | output | 16 | Handler FS selector |
| new_ds | output | 16 | Handler DS selector |
| new_es | output | 16 | Handler ES selector |

## Verification
The assertions check on every cycle that:
- successive accepted writes step down by four bytes;
- a stalled write keeps its address and data;
- done lasts one cycle and never overlaps a write;
- the selectors are null at done and the always-cleared flag bits are zero.

Only the bench's scenarios can show the content and order of the frame, the 36- versus 40-byte length, the dependence of the interrupt-enable bit on the gate type, the loaded entry point, and that a start during a frame is ignored. For these it compares every accepted write against a scoreboard under continuous and intermittent ready.

// File: rtl/vm86_frame_builder.sv
module vm86_frame_builder #(
  parameter int SEL_W = 16,
  parameter int W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] cur_gs,
  input  logic [SEL_W-1:0] cur_fs,
  input  logic [SEL_W-1:0] cur_ds,
  input  logic [SEL_W-1:0] cur_es,
  input  logic [SEL_W-1:0] cur_ss,
  input  logic [W-1:0]     cur_esp,
  input  logic [W-1:0]     cur_flags,
  input  logic [SEL_W-1:0] cur_cs,
  input  logic [W-1:0]     cur_eip,
  input  logic [SEL_W-1:0] gate_sel,
  input  logic [W-1:0]     gate_off,
  input  logic             gate_trap,
  input  logic             err_valid,
  input  logic [W-1:0]     err_code,
  input  logic [SEL_W-1:0] tss_ss0,
  input  logic [W-1:0]     tss_esp0,
  input  logic             wr_ready,
  output logic             wr_valid,
  output logic [W-1:0]     wr_addr,
  output logic [W-1:0]     wr_data,
  output logic             busy,
  output logic             done,
  output logic [SEL_W-1:0] new_ss,
  output logic [W-1:0]     new_esp,
  output logic [SEL_W-1:0] new_cs,
  output logic [W-1:0]     new_eip,
  output logic [W-1:0]     new_flags,
  output logic [SEL_W-1:0] new_gs,
  output logic [SEL_W-1:0] new_fs,
  output logic [SEL_W-1:0] new_ds,
  output logic [SEL_W-1:0] new_es
);
  localparam int          PAD      = W - SEL_W;
  localparam int          SLOT     = W / 8;
  localparam logic [W-1:0] CLR_ALL = (W'(1) << 8) | (W'(1) << 14) | (W'(1) << 16) | (W'(1) << 17);
  localparam logic [W-1:0] CLR_IF  = W'(1) << 9;

  logic [SEL_W-1:0] s_gs, s_fs, s_ds, s_es, s_ss, s_cs, s_gsel, s_ss0;
  logic [W-1:0]     s_esp, s_flags, s_eip, s_goff, s_err, sp;
  logic             s_trap, s_errv;
  logic [3:0]       idx;

  wire [3:0] last_idx = s_errv ? 4'd9 : 4'd8;
  wire       accept   = wr_valid && wr_ready;
  wire       finish   = accept && (idx == last_idx);

  assign wr_valid = busy;
  assign wr_addr  = sp - W'(SLOT);

  always_comb begin
    case (idx)
      4'd0:    wr_data = {{PAD{1'b0}}, s_gs};
      4'd1:    wr_data = {{PAD{1'b0}}, s_fs};
      4'd2:    wr_data = {{PAD{1'b0}}, s_ds};
      4'd3:    wr_data = {{PAD{1'b0}}, s_es};
      4'd4:    wr_data = {{PAD{1'b0}}, s_ss};
      4'd5:    wr_data = s_esp;
      4'd6:    wr_data = s_flags;
      4'd7:    wr_data = {{PAD{1'b0}}, s_cs};
      4'd8:    wr_data = s_eip;
      default: wr_data = s_err;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      sp   <= '0;
      {s_gs, s_fs, s_ds, s_es, s_ss, s_cs, s_gsel, s_ss0} <= '0;
      {s_esp, s_flags, s_eip, s_goff, s_err} <= '0;
      s_trap <= 1'b0;
      s_errv <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        idx     <= '0;
        sp      <= tss_esp0;
        s_gs    <= cur_gs;
        s_fs    <= cur_fs;
        s_ds    <= cur_ds;
        s_es    <= cur_es;
        s_ss    <= cur_ss;
        s_esp   <= cur_esp;
        s_flags <= cur_flags;
        s_cs    <= cur_cs;
        s_eip   <= cur_eip;
        s_gsel  <= gate_sel;
        s_goff  <= gate_off;
        s_trap  <= gate_trap;
        s_errv  <= err_valid;
        s_err   <= err_code;
        s_ss0   <= tss_ss0;
      end
    end else if (accept) begin
      sp  <= wr_addr;
      idx <= idx + 4'd1;
      if (finish) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      new_ss    <= '0;
      new_esp   <= '0;
      new_cs    <= '0;
      new_eip   <= '0;
      new_flags <= '0;
      new_gs    <= '0;
      new_fs    <= '0;
      new_ds    <= '0;
      new_es    <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        new_ss    <= s_ss0;
        new_esp   <= wr_addr;
        new_cs    <= s_gsel;
        new_eip   <= s_goff;
        new_flags <= s_flags & ~(CLR_ALL | (s_trap ? W'(0) : CLR_IF));
        new_gs    <= '0;
        new_fs    <= '0;
        new_ds    <= '0;
        new_es    <= '0;
      end
    end
  end
endmodule

// File: rtl/vm86_frame_builder_chk.sv
module vm86_frame_builder_chk #(
  parameter int SEL_W = 16,
  parameter int W     = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [W-1:0]     wr_addr,
  input logic [W-1:0]     wr_data,
  input logic             done,
  input logic [W-1:0]     new_flags,
  input logic [SEL_W-1:0] new_gs,
  input logic [SEL_W-1:0] new_fs,
  input logic [SEL_W-1:0] new_ds,
  input logic [SEL_W-1:0] new_es
);
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!wr_valid || wr_addr == $past(wr_addr) - W'(4))); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid); // R5
  AST_SEG_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (new_gs == '0 && new_fs == '0 && new_ds == '0 && new_es == '0)); // R8
  AST_FLAGS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (new_flags[8] == 1'b0 && new_flags[14] == 1'b0 &&
              new_flags[16] == 1'b0 && new_flags[17] == 1'b0)); // R9
endmodule

bind vm86_frame_builder vm86_frame_builder_chk #(.SEL_W(SEL_W), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .new_flags(new_flags),
  .new_gs(new_gs), .new_fs(new_fs), .new_ds(new_ds), .new_es(new_es)
);

// File: tb/sim_vm86_frame_builder.sv
module sim_vm86_frame_builder;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] cur_gs = 0, cur_fs = 0, cur_ds = 0, cur_es = 0, cur_ss = 0, cur_cs = 0;
  logic [31:0] cur_esp = 0, cur_flags = 0, cur_eip = 0;
  logic [15:0] gate_sel = 0, tss_ss0 = 0;
  logic [31:0] gate_off = 0, err_code = 0, tss_esp0 = 0;
  logic gate_trap = 0, err_valid = 0, wr_ready = 1, stall_en = 0;
  logic wr_valid, busy, done;
  logic [31:0] wr_addr, wr_data, new_esp, new_eip, new_flags;
  logic [15:0] new_ss, new_cs, new_gs, new_fs, new_ds, new_es;

  int checks = 0, fails = 0, cyc = 0;
  logic [63:0] expq[$];
  string tagq[$];

  always #(CLK_P/2) clk = ~clk;

  vm86_frame_builder u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk); #1;
    cyc++;
    wr_ready = stall_en ? (cyc % 3 != 1) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (expq.size() == 0) chk(0, "R5 extra write", {32'h0, wr_addr}, 64'h0);
      else begin
        logic [63:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(wr_addr == e[63:32], "R2 write address", {32'h0, wr_addr}, {32'h0, e[63:32]});
        chk(wr_data == e[31:0], t, {32'h0, wr_data}, {32'h0, e[31:0]});
      end
    end
  end

  task automatic run(input logic [31:0] esp0, input logic [31:0] fl, input bit trap,
                     input bit ev, input bit stall, input bit inject, input logic [15:0] seed);
    logic [31:0] a, exp_fl;
    bit seen;
    a = esp0;
    stall_en = stall;
    @(posedge clk); #1;
    cur_gs = seed + 1; cur_fs = seed + 2; cur_ds = seed + 3; cur_es = seed + 4;
    cur_ss = seed + 5; cur_esp = {seed, 16'h1230}; cur_flags = fl;
    cur_cs = seed + 6; cur_eip = {16'hbeef, seed};
    gate_sel = seed + 16'h0100; gate_off = {seed, 16'hc0de}; gate_trap = trap;
    err_valid = ev; err_code = {16'he000, seed}; tss_ss0 = seed + 16'h0010; tss_esp0 = esp0;
    a -= 4; expq.push_back({a, 16'h0, cur_gs});  tagq.push_back("R3 gs slot");
    a -= 4; expq.push_back({a, 16'h0, cur_fs});  tagq.push_back("R3 fs slot");
    a -= 4; expq.push_back({a, 16'h0, cur_ds});  tagq.push_back("R3 ds slot");
    a -= 4; expq.push_back({a, 16'h0, cur_es});  tagq.push_back("R3 es slot");
    a -= 4; expq.push_back({a, 16'h0, cur_ss});  tagq.push_back("R4 ss slot");
    a -= 4; expq.push_back({a, cur_esp});        tagq.push_back("R4 esp slot");
    a -= 4; expq.push_back({a, fl});             tagq.push_back("R4 flags slot");
    a -= 4; expq.push_back({a, 16'h0, cur_cs});  tagq.push_back("R4 cs slot");
    a -= 4; expq.push_back({a, cur_eip});        tagq.push_back("R4 eip slot");
    if (ev) begin a -= 4; expq.push_back({a, err_code}); tagq.push_back("R5 error slot"); end
    exp_fl = fl & ~(32'h0003_4100 | (trap ? 32'h0 : 32'h0000_0200));
    start = 1;
    @(posedge clk); #1;
    start = 0;
    if (inject) begin
      repeat (3) @(posedge clk); #1;
      tss_esp0 = 32'h0000_8000; tss_ss0 = 16'h7777; gate_sel = 16'h5555; err_valid = ~ev;
      start = 1;
      @(posedge clk); #1;
      start = 0;
    end
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, "R7 done seen", {63'h0, seen}, 64'h1);
    chk(expq.size() == 0, "R5 frame length", expq.size(), 64'h0);
    chk(new_esp == esp0 - (ev ? 32'd40 : 32'd36), inject ? "R11 esp unaffected" : "R7 final esp",
        {32'h0, new_esp}, {32'h0, esp0 - (ev ? 32'd40 : 32'd36)});
    chk(new_ss == seed + 16'h0010, inject ? "R11 ss unaffected" : "R7 new ss", {48'h0, new_ss}, {48'h0, seed + 16'h0010});
    chk({new_gs, new_fs, new_ds, new_es} == 64'h0, "R8 nulled selectors", {new_gs, new_fs, new_ds, new_es}, 64'h0);
    chk(new_flags == exp_fl, "R9 flags", {32'h0, new_flags}, {32'h0, exp_fl});
    chk(new_cs == seed + 16'h0100, "R10 code selector", {48'h0, new_cs}, {48'h0, seed + 16'h0100});
    chk(new_eip == {seed, 16'hc0de}, "R10 entry offset", {32'h0, new_eip}, {32'h0, seed, 16'hc0de});
    @(negedge clk);
    chk(!done, "R7 done one cycle", {63'h0, done}, 64'h0);
    chk(!wr_valid, "R11 no second frame", {63'h0, wr_valid}, 64'h0);
    expq.delete();
    tagq.delete();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!wr_valid && !done && new_esp == 0 && new_flags == 0 && new_cs == 0,
            "R1 reset outputs", {wr_valid, done, new_esp[29:0], new_flags}, 64'h0);
        #1 rst_n = 1;
        run(32'h0000_2000, 32'h0002_4302, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0010);
        run(32'h0001_0000, 32'h0003_ffff, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0220);
        run(32'h0000_0400, 32'hffff_ffff, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0330);
        run(32'h0000_3000, 32'h0002_0200, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0440);
        run(32'h0000_0028, 32'h0000_4300, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0550);
      end
      begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R7 watchdog expired: done=%0d expected 1", done);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule